// File: doc/BRIEF.md
# Accumulator-or-Memory Logic Execute Stage

This block is the execute step for the exclusive-OR and load operations of an 8-bit processor that has a mode bit. When the mode bit is clear, these operations work on the accumulator in the usual way. When the mode bit is set, the accumulator is left alone. The zero-page byte addressed by the X index register acts in its place, as both the left operand and the destination.

Operand fetch happens upstream. The block receives the fetched operand byte, the opcode, the current accumulator, X, the mode bit and the processor status byte. It returns the accumulator write, the status write and the strobes for a zero-page memory port.

In memory mode, exclusive-OR is a read-modify-write sequence on a synchronous memory that has one cycle of read latency. The block holds busy high for that sequence and ignores new operations until the sequence ends. Only the sign and zero flags change. Every other status bit keeps its value.

Top module: `tmode_alu_exec`

## Requirements
- R1: With t_mode low, an exclusive-OR opcode (8'h49 or 8'h45) that is accepted while idle gives acc_we high for exactly one cycle, one cycle after acceptance, with acc_out = acc_in ^ m_byte. No memory strobe is raised.
- R2: With t_mode low, a load opcode (8'hA9 or 8'hA5) gives the same one-cycle acc_we pulse, with acc_out = m_byte.
- R3: With t_mode high, a load gives one mem_we pulse one cycle after acceptance, with mem_addr = {8'h00, x_idx} and mem_wdata = m_byte. acc_we stays low and busy stays low.
- R4: With t_mode high, an exclusive-OR raises mem_re one cycle after acceptance at mem_addr = {8'h00, x_idx}. It takes mem_rdata on the following cycle. Two cycles after mem_re, it raises mem_we at the same address with mem_wdata = read byte ^ m_byte. acc_we stays low.
- R5: Every result comes with a flag_we pulse in the same cycle. psr_out bit 7 equals result bit 7, and psr_out bit 1 is set exactly when the result is zero. The other six bits equal psr_in as sampled at acceptance.
- R6: For a memory-mode exclusive-OR, busy is high for three consecutive cycles, starting one cycle after acceptance and covering the read, wait and write cycles. op_valid has no effect while busy is high.
- R7: Any opcode other than 8'h49, 8'h45, 8'hA9 or 8'hA5 raises no strobe (acc_we, flag_we, mem_re, mem_we) and leaves busy low.
- R8: During and right after synchronous reset, busy, acc_we, flag_we, mem_re and mem_we are all low.
- R9: At most one of acc_we, mem_re and mem_we is high in any cycle. Whenever mem_re or mem_we is high, the upper byte of mem_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered this cycle |
| opcode | input | 8 | Opcode of the offered operation |
| t_mode | input | 1 | Mode bit: high redirects the operation to the byte at X |
| m_byte | input | 8 | Fetched operand byte |
| x_idx | input | 8 | X index register |
| acc_in | input | 8 | Current accumulator |
| psr_in | input | 8 | Current processor status byte |
| busy | output | 1 | Read-modify-write sequence in progress |
| acc_we | output | 1 | Accumulator write strobe |
| acc_out | output | 8 | New accumulator value |
| flag_we | output | 1 | Status write strobe |
| psr_out | output | 8 | New status byte |
| mem_addr | output | 16 | Zero-page memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_re |

## Verification
The bench runs every operand value through all four mode and operation pairings, and uses a sign bit and zero results to exercise both flags. A design that takes the left operand from the accumulator in memory mode, or writes the accumulator there, fails the memory-content and acc_we checks.

The timing of the write is checked against the cycle of the read. A design that takes mem_rdata one cycle early writes stale data, and one that keeps busy low or drops it early accepts the operation that the bench holds on op_valid during the sequence. All 252 unused opcodes are offered to show that none of them raises a strobe. Arbitrary status bytes show whether the six untouched bits survive.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_XOR  = 2'd1,
    OP_LOAD = 2'd2
  } op_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MERGE = 2'd2,
    ST_STORE = 2'd3
  } seq_state_t;

  localparam logic [7:0] OPC_XOR_IMM  = 8'h49;
  localparam logic [7:0] OPC_XOR_ZP   = 8'h45;
  localparam logic [7:0] OPC_LOAD_IMM = 8'hA9;
  localparam logic [7:0] OPC_LOAD_ZP  = 8'hA5;

endpackage

// File: rtl/tm_op_decode.sv
module tm_op_decode
  import tm_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output op_kind_t         kind
);

  always_comb begin
    case (opcode)
      OPC_XOR_IMM,  OPC_XOR_ZP:  kind = OP_XOR;
      OPC_LOAD_IMM, OPC_LOAD_ZP: kind = OP_LOAD;
      default:                   kind = OP_NONE;
    endcase
  end

endmodule

// File: rtl/tm_logic_unit.sv
module tm_logic_unit
  import tm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_t          kind,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    case (kind)
      OP_XOR:  result = lhs ^ rhs;
      OP_LOAD: result = rhs;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/tm_flag_merge.sv
module tm_flag_merge #(
  parameter int DATA_W = 8,
  parameter int PSR_W  = 8,
  parameter int N_POS  = 7,
  parameter int Z_POS  = 1
) (
  input  logic [PSR_W-1:0]  psr_base,
  input  logic [DATA_W-1:0] result,
  output logic [PSR_W-1:0]  psr_new
);

  logic sign_bit;
  logic zero_bit;

  assign sign_bit = result[DATA_W-1];
  assign zero_bit = (result == '0);

  // Each status bit either takes a new flag or passes through unchanged.
  for (genvar b = 0; b < PSR_W; b++) begin : g_bit
    if (b == N_POS) begin : g_n
      assign psr_new[b] = sign_bit;
    end else if (b == Z_POS) begin : g_z
      assign psr_new[b] = zero_bit;
    end else begin : g_keep
      assign psr_new[b] = psr_base[b];
    end
  end

endmodule

// File: rtl/tm_seq_ctrl.sv
module tm_seq_ctrl
  import tm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_rmw,
  output seq_state_t state,
  output logic       busy
);

  seq_state_t state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (start_rmw) state_nxt = ST_FETCH;
      ST_FETCH: state_nxt = ST_MERGE;
      ST_MERGE: state_nxt = ST_STORE;
      ST_STORE: state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/tmode_alu_exec.sv
module tmode_alu_exec
  import tm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int PSR_W  = 8,
  parameter int N_POS  = 7,
  parameter int Z_POS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic              t_mode,
  input  logic [DATA_W-1:0] m_byte,
  input  logic [DATA_W-1:0] x_idx,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [PSR_W-1:0]  psr_in,
  output logic              busy,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_out,
  output logic              flag_we,
  output logic [PSR_W-1:0]  psr_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int PAGE_W = ADDR_W - DATA_W;

  op_kind_t          dec_kind;
  op_kind_t          lu_kind;
  seq_state_t        state;
  logic              seq_busy;
  logic              accept;
  logic              start_rmw;
  logic              in_merge;
  logic [DATA_W-1:0] lu_lhs;
  logic [DATA_W-1:0] lu_rhs;
  logic [DATA_W-1:0] lu_res;
  logic [PSR_W-1:0]  fm_base;
  logic [PSR_W-1:0]  fm_psr;
  logic [DATA_W-1:0] hold_m;
  logic [PSR_W-1:0]  hold_psr;

  tm_op_decode #(.OPC_W(8)) u_dec (
    .opcode (opcode),
    .kind   (dec_kind)
  );

  assign accept    = op_valid && !seq_busy && (dec_kind != OP_NONE);
  assign start_rmw = accept && t_mode && (dec_kind == OP_XOR);

  tm_seq_ctrl u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_rmw (start_rmw),
    .state     (state),
    .busy      (seq_busy)
  );

  // The logic unit is shared: at issue it sees the live inputs, and in the
  // merge cycle it sees the byte just read plus the captured operand.
  assign in_merge = (state == ST_MERGE);
  assign lu_kind  = in_merge ? OP_XOR    : dec_kind;
  assign lu_lhs   = in_merge ? mem_rdata : acc_in;
  assign lu_rhs   = in_merge ? hold_m    : m_byte;
  assign fm_base  = in_merge ? hold_psr  : psr_in;

  tm_logic_unit #(.DATA_W(DATA_W)) u_lu (
    .kind   (lu_kind),
    .lhs    (lu_lhs),
    .rhs    (lu_rhs),
    .result (lu_res)
  );

  tm_flag_merge #(
    .DATA_W (DATA_W),
    .PSR_W  (PSR_W),
    .N_POS  (N_POS),
    .Z_POS  (Z_POS)
  ) u_fm (
    .psr_base (fm_base),
    .result   (lu_res),
    .psr_new  (fm_psr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_we    <= 1'b0;
      flag_we   <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      acc_out   <= '0;
      psr_out   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hold_m    <= '0;
      hold_psr  <= '0;
    end else begin
      acc_we  <= 1'b0;
      flag_we <= 1'b0;
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      if (accept) begin
        hold_m   <= m_byte;
        hold_psr <= psr_in;
        if (!t_mode) begin
          acc_we  <= 1'b1;
          acc_out <= lu_res;
          flag_we <= 1'b1;
          psr_out <= fm_psr;
        end else if (dec_kind == OP_LOAD) begin
          mem_we    <= 1'b1;
          mem_addr  <= {{PAGE_W{1'b0}}, x_idx};
          mem_wdata <= lu_res;
          flag_we   <= 1'b1;
          psr_out   <= fm_psr;
        end else begin
          mem_re   <= 1'b1;
          mem_addr <= {{PAGE_W{1'b0}}, x_idx};
        end
      end else if (in_merge) begin
        mem_we    <= 1'b1;
        mem_wdata <= lu_res;
        flag_we   <= 1'b1;
        psr_out   <= fm_psr;
      end
    end
  end

  assign busy = seq_busy;

endmodule

// File: rtl/tmode_alu_exec_chk.sv
module tmode_alu_exec_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              acc_we,
  input logic              flag_we,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  // R9: strobes never overlap
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_we, mem_re, mem_we}));

  // R9: memory accesses stay in zero page
  a_r9_zero_page: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

  // R4: a wait cycle with no strobe follows the read
  a_r4_gap_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we && busy));

  // R4: the write lands two cycles after the read
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (rst)
    $past(mem_re, 2) |-> mem_we);

  // R5: a status write accompanies every result write
  a_r5_flags_with_result: assert property (@(posedge clk) disable iff (rst)
    flag_we == (acc_we || mem_we));

  // R6: busy drops right after the read-modify-write store
  a_r6_busy_release: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy) |=> !busy);

  // R8: quiet in the cycle after reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !acc_we && !mem_re && !mem_we && !flag_we));

endmodule

bind tmode_alu_exec tmode_alu_exec_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .acc_we   (acc_we),
  .flag_we  (flag_we),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/tmode_alu_exec_tb_top.sv
module tmode_alu_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [7:0]  opcode;
  logic        t_mode;
  logic [7:0]  m_byte, x_idx, acc_in, psr_in;
  logic        busy, acc_we, flag_we, mem_re, mem_we;
  logic [7:0]  acc_out, psr_out, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  logic [7:0]  zmem [256];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tmode_alu_exec dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .t_mode(t_mode), .m_byte(m_byte), .x_idx(x_idx), .acc_in(acc_in),
    .psr_in(psr_in), .busy(busy), .acc_we(acc_we), .acc_out(acc_out),
    .flag_we(flag_we), .psr_out(psr_out), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Synchronous zero-page memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= zmem[mem_addr[7:0]];
    if (mem_we) zmem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Observation record over a five-cycle window after acceptance
  int n_acc, n_re, n_we, n_flag, acc_i, re_i, we_i, flag_i;
  logic [7:0]  acc_v, we_v, flag_v;
  logic [15:0] re_a, we_a;
  logic [4:0]  busy_seen;

  task automatic observe();
    n_acc = 0; n_re = 0; n_we = 0; n_flag = 0;
    acc_i = -1; re_i = -1; we_i = -1; flag_i = -1; busy_seen = '0;
    for (int i = 0; i < 5; i++) begin
      if (acc_we)  begin n_acc++;  acc_i = i;  acc_v = acc_out; end
      if (mem_re)  begin n_re++;   re_i = i;   re_a = mem_addr; end
      if (mem_we)  begin n_we++;   we_i = i;   we_a = mem_addr; we_v = mem_wdata; end
      if (flag_we) begin n_flag++; flag_i = i; flag_v = psr_out; end
      busy_seen[i] = busy;
      if (i < 4) @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [7:0] opc, input logic t, input logic [7:0] m,
                        input logic [7:0] x, input logic [7:0] a, input logic [7:0] p,
                        input logic [7:0] seed);
    logic       is_xor, is_load;
    logic [7:0] lhs, res, exp_psr;
    is_xor  = (opc == 8'h49) || (opc == 8'h45);
    is_load = (opc == 8'hA9) || (opc == 8'hA5);
    @(negedge clk);
    zmem[x] = seed;
    lhs = t ? seed : a;
    res = is_xor ? (lhs ^ m) : m;
    exp_psr = p;
    exp_psr[7] = res[7];
    exp_psr[1] = (res == 8'h00);
    opcode = opc; t_mode = t; m_byte = m; x_idx = x; acc_in = a; psr_in = p;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    psr_in = ~p;
    acc_in = ~a;
    m_byte = ~m;
    observe();
    if (!is_xor && !is_load) begin
      check(n_acc + n_re + n_we + n_flag == 0, "R7 strobes", n_acc + n_re + n_we + n_flag, 0);
      check(busy_seen == 5'b0, "R7 busy", busy_seen, 0);
    end else begin
      check(n_flag == 1, "R5 flag_we count", n_flag, 1);
      check(flag_v == exp_psr, "R5 psr_out", flag_v, exp_psr);
      if (!t) begin
        check(n_acc == 1 && acc_i == 0, is_xor ? "R1 acc_we timing" : "R2 acc_we timing", acc_i, 0);
        check(acc_v == res, is_xor ? "R1 acc_out" : "R2 acc_out", acc_v, res);
        check(n_re + n_we == 0, "R1 no memory access", n_re + n_we, 0);
        check(zmem[x] == seed, "R2 memory untouched", zmem[x], seed);
      end else if (is_load) begin
        check(n_we == 1 && we_i == 0 && n_re == 0, "R3 mem_we timing", we_i, 0);
        check(we_a == {8'h00, x} && we_v == m, "R3 write addr/data", {we_a, we_v}, {8'h00, x, m});
        check(n_acc == 0 && busy_seen == 5'b0, "R3 acc and busy quiet", {n_acc, busy_seen}, 0);
        check(zmem[x] == res, "R3 memory result", zmem[x], res);
      end else begin
        check(n_re == 1 && re_i == 0 && re_a == {8'h00, x}, "R4 read", {re_i, re_a}, {8'h00, x});
        check(n_we == 1 && we_i == 2 && we_a == {8'h00, x}, "R4 write slot", we_i, 2);
        check(we_v == res, "R4 write data", we_v, res);
        check(n_acc == 0, "R4 accumulator untouched", n_acc, 0);
        check(busy_seen == 5'b00111, "R6 busy window", busy_seen, 5'b00111);
        check(flag_i == 2, "R5 flag timing", flag_i, 2);
        check(zmem[x] == res, "R4 memory result", zmem[x], res);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; opcode = 8'h00; t_mode = 1'b0;
    m_byte = '0; x_idx = '0; acc_in = '0; psr_in = '0;
    for (int i = 0; i < 256; i++) zmem[i] = 8'(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: quiet after reset
    check(!busy && !acc_we && !flag_we && !mem_re && !mem_we, "R8 reset state",
          {busy, acc_we, flag_we, mem_re, mem_we}, 0);

    // R1 R2 R3 R4 R5: full operand sweep in all four mode and operation pairings
    for (int v = 0; v < 256; v++) begin
      logic [7:0] m, a, p, x, s;
      m = 8'(v);
      a = 8'(v * 37 + 11);
      p = 8'(v ^ 8'hC3);
      x = 8'(v ^ 8'h5A);
      s = 8'(v * 3 + 1);
      run_op((v % 2) ? 8'h49 : 8'h45, 1'b0, m, x, (v % 16 == 0) ? m : a, p, s);
      run_op((v % 2) ? 8'hA5 : 8'hA9, 1'b0, m, x, a, p, s);
      run_op((v % 2) ? 8'hA9 : 8'hA5, 1'b1, m, x, a, p, s);
      run_op((v % 2) ? 8'h45 : 8'h49, 1'b1, m, x, a, p, (v % 16 == 0) ? m : s);
    end

    // R7: every unused opcode, in both modes
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h49 && o != 8'h45 && o != 8'hA9 && o != 8'hA5)
        run_op(8'(o), 1'(o % 2), 8'(o), 8'(o + 1), 8'(o + 2), 8'(o + 3), 8'(o));
    end

    // R6: an operation held on op_valid during the busy window is ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      zmem[8'(k + 16)] = 8'h0F;
      opcode = 8'h49; t_mode = 1'b1; m_byte = 8'(k); x_idx = 8'(k + 16);
      acc_in = 8'h00; psr_in = 8'h00; op_valid = 1'b1;
      @(negedge clk);
      opcode = 8'hA9; t_mode = 1'b0; m_byte = 8'hEE;
      n_acc = 0;
      for (int i = 0; i < 5; i++) begin
        if (i == 3) op_valid = 1'b0;
        if (acc_we) n_acc++;
        @(negedge clk);
      end
      check(n_acc == 0, "R6 op ignored while busy", n_acc, 0);
      check(zmem[8'(k + 16)] == (8'h0F ^ 8'(k)), "R6 sequence completed", zmem[8'(k + 16)], 8'h0F ^ 8'(k));
    end

    finish_run();
  end

endmodule